// File: doc/BRIEF.md
# Branch Condition and Program Counter Sequencer

This block is the next-address stage of a small sequential controller core. For each instruction step it decides where execution continues. The choices are the following address, an absolute target, a target held in a register, a relative branch, a subroutine call, or a return from a subroutine. Conditional relative branches test a 4-bit condition code against the zero, negative, carry and overflow flags. Two further branch forms test one bit of an external event vector, picked by an index.

Calls and returns share a small return-address stack inside the block. A call saves the address after the call instruction and then jumps. A return takes the most recent saved address. If a call is made while the stack is full, the oldest saved address is lost. If a return is made while the stack is empty, execution goes to address 0. Each of these two cases raises its own status flag for one step. The decoder drives a branch kind and its operands, and asserts `advance` once per completed instruction. The program counter changes only on those cycles.

Top module: `pcSequencer`

## Requirements
- R1: After reset the program counter equals RESET_PC (default 0), both stack status flags are 0, and the return stack is empty.
- R2: While `advance` is 0 the program counter and the stack do not change, whatever the other inputs are.
- R3: With `advance` high and branch kind 0 (sequential), or any kind code 10 to 15, the next program counter is the current one plus 1, and `taken` is 0.
- R4: Kind 1 loads the program counter from `absTarget`. Kind 2 loads it from `regTarget`. Both drive `taken` high.
- R5: Kind 3 (branch always) sets the program counter to current + 1 + `relOffset`. The offset is a two's-complement value, and the sum wraps modulo 2^PC_W.
- R6: Kind 4 (conditional branch) uses the unsigned condition codes. Code 0 is higher (!C & !Z). Code 1 is higher-or-same, which is also "tested bit clear" (!C). Code 8 is lower-or-same (C | Z). Code 9 is lower, which is also "tested bit set" (C). A taken branch behaves as in R5. An untaken branch behaves as in R3.
- R7: Kind 4 uses the signed condition codes. Code 5 is greater-or-equal (N == V). Code 13 is less (N != V). Code 6 is greater (N == V and !Z). Code 14 is less-or-equal (N != V or Z).
- R8: Kind 4 uses the single-flag codes. Code 2 is Z. Code 10 is !Z. Code 3 is !V. Code 11 is V. Code 4 is !N. Code 12 is N. Codes 7 and 15 are never taken.
- R9: Kind 8 branches relatively when `evtVec[evtIdx]` is 0. Kind 9 branches relatively when that bit is 1. Otherwise the program counter advances by 1. `taken` shows the outcome.
- R10: Kind 5 (call to `absTarget`) and kind 6 (call to `regTarget`) push current + 1 and then jump. Kind 7 (return) loads the most recently pushed address and removes it. Saved addresses come back in last-in, first-out order.
- R11: A call made while STACK_DEPTH addresses are already saved discards the oldest saved address. It sets `stackOvf` to 1 for the next step only. The newer addresses still return in the correct order.
- R12: A return made with an empty stack loads the program counter with 0. It sets `stackUnf` to 1 until the next advancing step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Instruction step completes this cycle |
| brKind | input | 4 | Decoded branch kind (codes per R3 to R10) |
| condCode | input | 4 | Condition code for kind 4 |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| flagC | input | 1 | Carry flag, also tested I/O bit |
| flagV | input | 1 | Overflow flag |
| absTarget | input | PC_W | Absolute jump or call address |
| regTarget | input | PC_W | Register-held jump or call address |
| relOffset | input | PC_W | Two's-complement relative offset |
| evtIdx | input | $clog2(EVT_W) | Event bit selector |
| evtVec | input | EVT_W | Event inputs |
| pc | output | PC_W | Current program counter |
| taken | output | 1 | Current inputs redirect the flow (combinational) |
| stackOvf | output | 1 | Last step pushed onto a full stack |
| stackUnf | output | 1 | Last step popped an empty stack |

## Verification
The bench builds the block with PC_W = 10, STACK_DEPTH = 3 and EVT_W = 8. The narrow program counter lets one relative branch cross the top of the address space and wrap. The shallow stack lets four nested calls reach the overflow case and a short run of returns reach underflow. Every condition code is checked against all sixteen combinations of the four flags.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [3:0] {
    K_SEQ  = 4'd0,
    K_JABS = 4'd1,
    K_JREG = 4'd2,
    K_BRA  = 4'd3,
    K_BCC  = 4'd4,
    K_CABS = 4'd5,
    K_CREG = 4'd6,
    K_RET  = 4'd7,
    K_BEV0 = 4'd8,
    K_BEV1 = 4'd9
  } kind_e;

  typedef enum logic [2:0] {
    SRC_INC = 3'd0,
    SRC_ABS = 3'd1,
    SRC_REG = 3'd2,
    SRC_REL = 3'd3,
    SRC_POP = 3'd4
  } src_e;

  typedef struct packed {
    src_e src;
    logic push;
    logic pop;
  } strobe_t;

endpackage

// File: rtl/condEval.sv
module condEval (
  input  logic [3:0] code,
  input  logic       z,
  input  logic       n,
  input  logic       c,
  input  logic       v,
  output logic       hit
);
  logic sameSign;
  logic base;

  // Codes 8..14 are the complement of codes 0..6; low field 7 never fires.
  always_comb begin
    sameSign = (n == v);
    case (code[2:0])
      3'd0:    base = !c && !z;
      3'd1:    base = !c;
      3'd2:    base = z;
      3'd3:    base = !v;
      3'd4:    base = !n;
      3'd5:    base = sameSign;
      3'd6:    base = sameSign && !z;
      default: base = 1'b0;
    endcase
    hit = (code[2:0] == 3'd7) ? 1'b0 : (base ^ code[3]);
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import pcseq_pkg::*;
#(
  parameter int EVT_W     = 16,
  parameter int EVT_IDX_W = $clog2(EVT_W)
) (
  input  logic [3:0]           brKind,
  input  logic [3:0]           condCode,
  input  logic                 flagZ,
  input  logic                 flagN,
  input  logic                 flagC,
  input  logic                 flagV,
  input  logic [EVT_IDX_W-1:0] evtIdx,
  input  logic [EVT_W-1:0]     evtVec,
  output strobe_t              stb,
  output logic                 taken
);
  logic condHit;
  logic evtBit;

  condEval u_cond (
    .code(condCode),
    .z   (flagZ),
    .n   (flagN),
    .c   (flagC),
    .v   (flagV),
    .hit (condHit)
  );

  assign evtBit = evtVec[evtIdx];

  always_comb begin
    stb   = '{src: SRC_INC, push: 1'b0, pop: 1'b0};
    taken = 1'b0;
    case (kind_e'(brKind))
      K_JABS: begin stb.src = SRC_ABS; taken = 1'b1; end
      K_JREG: begin stb.src = SRC_REG; taken = 1'b1; end
      K_BRA:  begin stb.src = SRC_REL; taken = 1'b1; end
      K_BCC:  taken = condHit;
      K_CABS: begin stb.src = SRC_ABS; stb.push = 1'b1; taken = 1'b1; end
      K_CREG: begin stb.src = SRC_REG; stb.push = 1'b1; taken = 1'b1; end
      K_RET:  begin stb.src = SRC_POP; stb.pop = 1'b1; taken = 1'b1; end
      K_BEV0: taken = !evtBit;
      K_BEV1: taken = evtBit;
      default: ;
    endcase
    if ((kind_e'(brKind) == K_BCC || kind_e'(brKind) == K_BEV0 ||
         kind_e'(brKind) == K_BEV1) && taken)
      stb.src = SRC_REL;
  end
endmodule

// File: rtl/retStack.sv
module retStack #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] pushData,
  output logic [W-1:0] popData,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] topIdx;
  logic [CNT_W-1:0] cnt;

  assign topIdx  = (wrPtr == '0) ? LAST_IDX : wrPtr - 1'b1;
  assign full    = (cnt == CNT_MAX);
  assign empty   = (cnt == '0);
  assign popData = empty ? '0 : slots[topIdx];

  // Circular buffer: a push when full overwrites the oldest slot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else if (push) begin
      slots[wrPtr] <= pushData;
      wrPtr        <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (!full) cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      wrPtr <= topIdx;
      cnt   <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import pcseq_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int DEPTH    = 4,
  parameter int RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            advance,
  input  strobe_t         stb,
  input  logic [PC_W-1:0] absTarget,
  input  logic [PC_W-1:0] regTarget,
  input  logic [PC_W-1:0] relOffset,
  output logic [PC_W-1:0] pc,
  output logic            stackOvf,
  output logic            stackUnf
);
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] relTgt;
  logic [PC_W-1:0] popData;
  logic [PC_W-1:0] nextPc;
  logic            stkFull;
  logic            stkEmpty;

  assign pcInc  = pc + 1'b1;
  assign relTgt = pcInc + relOffset;

  retStack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rstN    (rstN),
    .push    (advance && stb.push),
    .pop     (advance && stb.pop),
    .pushData(pcInc),
    .popData (popData),
    .full    (stkFull),
    .empty   (stkEmpty)
  );

  always_comb begin
    case (stb.src)
      SRC_ABS: nextPc = absTarget;
      SRC_REG: nextPc = regTarget;
      SRC_REL: nextPc = relTgt;
      SRC_POP: nextPc = popData;
      default: nextPc = pcInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= PC_W'(RESET_PC);
      stackOvf <= 1'b0;
      stackUnf <= 1'b0;
    end else if (advance) begin
      pc       <= nextPc;
      stackOvf <= stb.push && stkFull;
      stackUnf <= stb.pop && stkEmpty;
    end
  end
endmodule

// File: rtl/pcSequencer.sv
module pcSequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int STACK_DEPTH = 4,
  parameter int EVT_W       = 16,
  parameter int RESET_PC    = 0,
  localparam int EVT_IDX_W  = $clog2(EVT_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 advance,
  input  logic [3:0]           brKind,
  input  logic [3:0]           condCode,
  input  logic                 flagZ,
  input  logic                 flagN,
  input  logic                 flagC,
  input  logic                 flagV,
  input  logic [PC_W-1:0]      absTarget,
  input  logic [PC_W-1:0]      regTarget,
  input  logic [PC_W-1:0]      relOffset,
  input  logic [EVT_IDX_W-1:0] evtIdx,
  input  logic [EVT_W-1:0]     evtVec,
  output logic [PC_W-1:0]      pc,
  output logic                 taken,
  output logic                 stackOvf,
  output logic                 stackUnf
);
  strobe_t stb;

  seqControl #(.EVT_W(EVT_W), .EVT_IDX_W(EVT_IDX_W)) u_ctrl (
    .brKind  (brKind),
    .condCode(condCode),
    .flagZ   (flagZ),
    .flagN   (flagN),
    .flagC   (flagC),
    .flagV   (flagV),
    .evtIdx  (evtIdx),
    .evtVec  (evtVec),
    .stb     (stb),
    .taken   (taken)
  );

  seqDatapath #(.PC_W(PC_W), .DEPTH(STACK_DEPTH), .RESET_PC(RESET_PC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .advance  (advance),
    .stb      (stb),
    .absTarget(absTarget),
    .regTarget(regTarget),
    .relOffset(relOffset),
    .pc       (pc),
    .stackOvf (stackOvf),
    .stackUnf (stackUnf)
  );
endmodule

// File: rtl/pcSequencer_chk.sv
module pcSequencer_chk #(
  parameter int PC_W        = 16,
  parameter int STACK_DEPTH = 4,
  parameter int EVT_W       = 16,
  parameter int RESET_PC    = 0,
  localparam int EVT_IDX_W  = $clog2(EVT_W)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 advance,
  input logic [3:0]           brKind,
  input logic [3:0]           condCode,
  input logic                 flagZ,
  input logic                 flagN,
  input logic                 flagC,
  input logic                 flagV,
  input logic [PC_W-1:0]      absTarget,
  input logic [PC_W-1:0]      regTarget,
  input logic [PC_W-1:0]      relOffset,
  input logic [EVT_IDX_W-1:0] evtIdx,
  input logic [EVT_W-1:0]     evtVec,
  input logic [PC_W-1:0]      pc,
  input logic                 taken,
  input logic                 stackOvf,
  input logic                 stackUnf
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(pc));

  p_seq_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && brKind == 4'd0) |=> pc == $past(pc) + PC_W'(1));

  p_abs_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    (advance && brKind == 4'd1) |=> pc == $past(absTarget));

  p_reg_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    (advance && brKind == 4'd2) |=> pc == $past(regTarget));

  p_rel_branch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && brKind == 4'd3) |=> pc == $past(pc) + PC_W'(1) + $past(relOffset));

  p_carry_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 4'd4 && condCode == 4'd9) |-> taken == flagC);

  p_zero_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 4'd4 && condCode == 4'd2) |-> taken == flagZ);

  p_neg_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 4'd4 && condCode == 4'd12) |-> taken == flagN);

  p_ovf_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 4'd4 && condCode == 4'd11) |-> taken == flagV);

  p_never_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 4'd4 && condCode[2:0] == 3'd7) |-> !taken);

  p_event_r9: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 4'd9) |-> taken == evtVec[evtIdx]);

  p_call_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    (advance && brKind == 4'd5) |=> pc == $past(absTarget));

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(stackOvf && stackUnf));

  p_ovf_only_on_call_r11: assert property (@(posedge clk) disable iff (!rstN)
    (advance && brKind != 4'd5 && brKind != 4'd6) |=> !stackOvf);

  p_underflow_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (advance && brKind == 4'd7) |=> (stackUnf |-> pc == '0));
endmodule

bind pcSequencer pcSequencer_chk #(
  .PC_W(PC_W), .STACK_DEPTH(STACK_DEPTH), .EVT_W(EVT_W), .RESET_PC(RESET_PC)
) u_chk (.*);

// File: tb/tb_pcSequencer.sv
module tb_pcSequencer;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 10;
  localparam int SD  = 3;
  localparam int EW  = 8;
  localparam int EIW = $clog2(EW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          advance = 1'b0;
  logic [3:0]    brKind = '0;
  logic [3:0]    condCode = '0;
  logic          flagZ = 0, flagN = 0, flagC = 0, flagV = 0;
  logic [PW-1:0] absTarget = '0, regTarget = '0, relOffset = '0;
  logic [EIW-1:0] evtIdx = '0;
  logic [EW-1:0] evtVec = '0;
  logic [PW-1:0] pc;
  logic          taken, stackOvf, stackUnf;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  pcSequencer #(.PC_W(PW), .STACK_DEPTH(SD), .EVT_W(EW), .RESET_PC(0)) dut (.*);

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One advancing step: inputs set at the falling edge, outputs read after the rising edge.
  task automatic step(input logic [3:0] k, input logic [PW-1:0] a, input logic [PW-1:0] r,
                      input logic [PW-1:0] off);
    @(negedge clk);
    brKind = k; absTarget = a; regTarget = r; relOffset = off; advance = 1'b1;
    @(posedge clk);
    #1 advance = 1'b0;
  endtask

  function automatic logic refCond(input int code, input logic z, input logic n,
                                   input logic c, input logic v);
    case (code)
      0:  return !c && !z;
      1:  return !c;
      2:  return z;
      3:  return !v;
      4:  return !n;
      5:  return n == v;
      6:  return (n == v) && !z;
      8:  return c || z;
      9:  return c;
      10: return !z;
      11: return v;
      12: return n;
      13: return n != v;
      14: return (n != v) || z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagOf(input int code);
    if (code == 0 || code == 1 || code == 8 || code == 9) return "R6";
    if (code == 5 || code == 6 || code == 13 || code == 14) return "R7";
    return "R8";
  endfunction

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 ovf", stackOvf, 0);
    chk("R1 unf", stackUnf, 0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    brKind = 4'd1; absTarget = 10'h155; advance = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R2 hold pc", pc, 0);
    brKind = 4'd7;
    repeat (2) @(posedge clk);
    #1 chk("R2 hold no pop", pc, 0);
    chk("R2 hold no unf", stackUnf, 0);
  endtask

  task automatic t_seq();
    step(4'd0, 10'h3FF, 10'h3FF, 10'h10);
    chk("R3 seq", pc, 1);
    step(4'd0, '0, '0, '0);
    chk("R3 seq2", pc, 2);
    @(negedge clk); brKind = 4'd12; #1 chk("R3 taken unused kind", taken, 0);
    step(4'd12, 10'h200, 10'h200, 10'h20);
    chk("R3 unused kind", pc, 3);
  endtask

  task automatic t_jumps();
    step(4'd1, 10'h100, 10'h2A0, '0);
    chk("R4 abs", pc, 10'h100);
    step(4'd2, 10'h100, 10'h2A0, '0);
    chk("R4 reg", pc, 10'h2A0);
  endtask

  task automatic t_rel();
    step(4'd1, 10'h040, '0, '0);
    step(4'd3, '0, '0, 10'd5);
    chk("R5 fwd", pc, 10'h046);
    step(4'd3, '0, '0, -10'sd3);
    chk("R5 back", pc, 10'h044);
    step(4'd1, 10'h3FE, '0, '0);
    step(4'd3, '0, '0, 10'd3);
    chk("R5 wrap", pc, 10'h002);
  endtask

  task automatic t_cond();
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        brKind = 4'd4; condCode = 4'(code); advance = 1'b0;
        {flagZ, flagN, flagC, flagV} = 4'(f);
        #1 chk($sformatf("%s code %0d flags %0h", tagOf(code), code, f), taken,
               refCond(code, f[3], f[2], f[1], f[0]));
      end
    end
    // taken unsigned branch (code 9, C=1)
    step(4'd1, 10'h080, '0, '0);
    @(negedge clk); condCode = 4'd9; {flagZ, flagN, flagC, flagV} = 4'b0010;
    step(4'd4, '0, '0, 10'd7);
    chk("R6 taken pc", pc, 10'h088);
    // untaken signed branch (code 6 with Z=1)
    @(negedge clk); condCode = 4'd6; {flagZ, flagN, flagC, flagV} = 4'b1000;
    step(4'd4, '0, '0, 10'd7);
    chk("R7 untaken pc", pc, 10'h089);
    @(negedge clk); condCode = 4'd15;
    step(4'd4, '0, '0, 10'd7);
    chk("R8 never pc", pc, 10'h08A);
  endtask

  task automatic t_event();
    @(negedge clk); evtVec = 8'b0010_0100;
    step(4'd1, 10'h010, '0, '0);
    @(negedge clk); evtIdx = 3'd2; brKind = 4'd9; #1 chk("R9 taken bev1", taken, 1);
    step(4'd9, '0, '0, 10'd4);
    chk("R9 bev1 set", pc, 10'h015);
    step(4'd8, '0, '0, 10'd4);
    chk("R9 bev0 set", pc, 10'h016);
    @(negedge clk); evtIdx = 3'd3;
    step(4'd8, '0, '0, -10'sd2);
    chk("R9 bev0 clear", pc, 10'h015);
    @(negedge clk); evtIdx = 3'd0;
    step(4'd9, '0, '0, 10'd9);
    chk("R9 bev1 clear", pc, 10'h016);
  endtask

  task automatic t_call();
    step(4'd1, 10'h020, '0, '0);
    step(4'd5, 10'h050, '0, '0);
    chk("R10 call abs", pc, 10'h050);
    step(4'd6, '0, 10'h070, '0);
    chk("R10 call reg", pc, 10'h070);
    step(4'd7, '0, '0, '0);
    chk("R10 ret inner", pc, 10'h051);
    step(4'd7, '0, '0, '0);
    chk("R10 ret outer", pc, 10'h021);
    chk("R10 no unf", stackUnf, 0);
  endtask

  task automatic t_overflow();
    step(4'd1, 10'h040, '0, '0);
    step(4'd5, 10'h080, '0, '0);
    step(4'd5, 10'h0C0, '0, '0);
    step(4'd5, 10'h100, '0, '0);
    chk("R11 no ovf at depth", stackOvf, 0);
    step(4'd5, 10'h140, '0, '0);
    chk("R11 ovf", stackOvf, 1);
    chk("R11 pc", pc, 10'h140);
    step(4'd7, '0, '0, '0);
    chk("R11 ret1", pc, 10'h101);
    chk("R11 ovf clear", stackOvf, 0);
    step(4'd7, '0, '0, '0);
    chk("R11 ret2", pc, 10'h0C1);
    step(4'd7, '0, '0, '0);
    chk("R11 ret3", pc, 10'h081);
    step(4'd7, '0, '0, '0);
    chk("R12 oldest lost pc", pc, 0);
    chk("R12 unf after drop", stackUnf, 1);
  endtask

  task automatic t_underflow();
    step(4'd1, 10'h123, '0, '0);
    chk("R12 unf cleared by step", stackUnf, 0);
    step(4'd7, '0, '0, '0);
    chk("R12 pc zero", pc, 0);
    chk("R12 unf", stackUnf, 1);
    repeat (2) @(posedge clk);
    #1 chk("R12 unf held", stackUnf, 1);
    step(4'd0, '0, '0, '0);
    chk("R12 unf clear", stackUnf, 0);
    chk("R12 pc after", pc, 1);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_seq();
    t_jumps();
    t_rel();
    t_cond();
    t_event();
    t_call();
    t_overflow();
    t_underflow();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule